// File: doc/BRIEF.md
# TLP to 64-bit Stream Packer

This block takes a transaction-layer packet as a sequence of 32-bit dwords and repacks it into 64-bit beats. The source hands over one dword per handshake: first the header (three or four dwords), then any payload. The block reads the size of the header and the payload length from the first header dword. It counts dwords itself, so the source provides no framing signals. Each 64-bit beat has a lower lane (bits 31:0) and an upper lane (bits 63:32).

Payload is quadword aligned. The first payload dword always goes to the lane chosen by bit 2 of the last header dword, which carries the low address. This holds even when that dword does not contain a real address. Depending on header size and alignment, a gap of one empty lane may sit between the header and the data. Per-lane valid flags mark the empty lanes.

Both sides use a valid/ready handshake. A transfer takes place on a rising edge when valid and ready are both high. While the output is offered but not taken, the beat stays unchanged and the block stops accepting new dwords. The source may drop valid between dwords at any time.

Top module: `tlp_stream_packer`

## Requirements
- R1: Header dword k goes to beat k/2. Even k uses the lower lane (bits 31:0) and odd k uses the upper lane (bits 63:32). So beat 0 is {Header1, Header0}, and beat 1 holds Header2 and, for a four-dword header, Header3.
- R2: In the first header dword, bit 29 set means a four-dword header, and clear means three. Bit 30 set means a payload follows. Bits 9:0 give the payload length in dwords, and a value of 0 means 1024.
- R3: With a three-dword header and bit 2 of Header2 set, Data0 shares beat 1 in the upper lane. Data dword i then lands in beat 1 + (i+1)/2, in the lane of parity (i+1).
- R4: With a three-dword header and bit 2 of Header2 clear, the upper lane of beat 1 stays empty. Data0 starts in the lower lane of beat 2.
- R5: With a four-dword header, data begins in beat 2. Data0 goes in the lower lane when bit 2 of Header3 is clear. When that bit is set, Data0 goes in the upper lane and the lower lane of beat 2 is empty.
- R6: out_sop is high on the first beat of a packet only. out_eop is high only on the beat holding the packet's final dword.
- R7: out_lane_vld[0] flags the lower lane and out_lane_vld[1] flags the upper lane. An empty lane carries all zeros, and every offered beat has at least one valid lane.
- R8: While out_valid is high and out_ready is low, out_data, out_lane_vld, out_sop and out_eop hold their values.
- R9: in_ready is low whenever out_valid is high and out_ready is low. Dwords offered while in_ready is low are not consumed.
- R10: A packet without payload (bit 30 clear) ends after its last header dword, whatever the length field holds.
- R11: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source dword valid |
| in_ready | output | 1 | Block can take a dword |
| in_data | input | 32 | Header or payload dword |
| out_valid | output | 1 | Beat valid |
| out_ready | input | 1 | Sink accepts beat |
| out_data | output | 64 | Beat, lower lane in bits 31:0 |
| out_sop | output | 1 | First beat of packet |
| out_eop | output | 1 | Last beat of packet |
| out_lane_vld | output | 2 | Per-lane valid, bit 0 lower |

## Verification
The bench builds the block with its default length field width of 10 bits. This makes the full 1024-dword payload, written as a zero length, reachable within the run. That case exercises the width of the payload counter and the point where it wraps. The bench covers all four combinations of header size and address parity, as well as packets without payload. It also runs them under a sink that stalls every third cycle and under a source that leaves gaps.

// File: rtl/tlp_pack_pkg.sv
package tlp_pack_pkg;
  localparam int DW_W       = 32;
  localparam int LANES      = 2;
  localparam int BEAT_W     = DW_W * LANES;
  localparam int BIT_HAS_PAY = 30;
  localparam int BIT_HDR4    = 29;
  localparam int BIT_QW_ADDR = 2;

  typedef struct packed {
    logic [BEAT_W-1:0] data;
    logic [LANES-1:0]  lane_vld;
    logic              sop;
    logic              eop;
  } beat_t;
endpackage

// File: rtl/tlp_hdr_decode.sv
module tlp_hdr_decode #(
  parameter int LEN_W = 10
) (
  input  logic             has_pay_i,
  input  logic             hdr4_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [2:0]       hdr_dws_o,
  output logic [LEN_W:0]   pay_dws_o
);
  localparam logic [LEN_W:0] MAX_LEN = {1'b1, {LEN_W{1'b0}}};

  always_comb begin
    hdr_dws_o = hdr4_i ? 3'd4 : 3'd3;
    if (!has_pay_i)
      pay_dws_o = '0;
    else if (len_i == '0)
      pay_dws_o = MAX_LEN;
    else
      pay_dws_o = {1'b0, len_i};
  end
endmodule

// File: rtl/tlp_lane_asm.sv
module tlp_lane_asm
  import tlp_pack_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic [DW_W-1:0] dw_i,
  input  logic [2:0]      hdr_dws_i,
  input  logic [LEN_W:0]  pay_dws_i,
  output logic            push_o,
  output beat_t           beat_o
);
  logic             in_pkt_q;
  logic [2:0]       hdr_rem_q;
  logic [LEN_W:0]   dat_rem_q;
  logic             lane_q;
  logic [DW_W-1:0]  lo_q;
  logic             lo_vld_q;
  logic             sop_q;

  logic             first;
  logic [2:0]       hdr_cur;
  logic [LEN_W:0]   dat_cur;
  logic             lane_cur;
  logic             in_hdr;
  logic             last_hdr;
  logic             last_dw;
  logic             addr_odd;
  logic             flush;

  always_comb begin
    first    = !in_pkt_q;
    hdr_cur  = first ? hdr_dws_i : hdr_rem_q;
    dat_cur  = first ? pay_dws_i : dat_rem_q;
    lane_cur = first ? 1'b0 : lane_q;
    in_hdr   = (hdr_cur != 3'd0);
    last_hdr = (hdr_cur == 3'd1);
    addr_odd = dw_i[BIT_QW_ADDR];
    last_dw  = in_hdr ? (last_hdr && (dat_cur == '0))
                      : (dat_cur == {{LEN_W{1'b0}}, 1'b1});
    // a beat closes on its upper lane, on the final dword, or when the
    // header ends in the lower lane and data must restart on an even slot
    flush    = lane_cur || last_dw || (last_hdr && !addr_odd);
  end

  always_comb begin
    push_o          = take_i && flush;
    beat_o.sop      = sop_q || first;
    beat_o.eop      = last_dw;
    beat_o.lane_vld = {lane_cur, lane_cur ? lo_vld_q : 1'b1};
    beat_o.data     = {lane_cur ? dw_i : '0, lane_cur ? lo_q : dw_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt_q  <= 1'b0;
      hdr_rem_q <= '0;
      dat_rem_q <= '0;
      lane_q    <= 1'b0;
      lo_q      <= '0;
      lo_vld_q  <= 1'b0;
      sop_q     <= 1'b0;
    end else if (take_i) begin
      in_pkt_q  <= !last_dw;
      hdr_rem_q <= in_hdr ? hdr_cur - 3'd1 : 3'd0;
      dat_rem_q <= in_hdr ? dat_cur : dat_cur - 1'b1;
      lane_q    <= last_hdr ? addr_odd : !lane_cur;
      if (flush) begin
        lo_q     <= '0;
        lo_vld_q <= 1'b0;
        sop_q    <= 1'b0;
      end else begin
        lo_q     <= dw_i;
        lo_vld_q <= 1'b1;
        sop_q    <= sop_q || first;
      end
    end
  end
endmodule

// File: rtl/tlp_beat_reg.sv
module tlp_beat_reg
  import tlp_pack_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_i,
  input  beat_t beat_i,
  input  logic  ready_i,
  output logic  valid_o,
  output logic  space_o,
  output beat_t beat_o
);
  logic valid_q;

  assign space_o = !valid_q || ready_i;
  assign valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      valid_q <= 1'b0;
    else if (push_i)
      valid_q <= 1'b1;
    else if (ready_i)
      valid_q <= 1'b0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        beat_o.data[g*DW_W +: DW_W] <= '0;
        beat_o.lane_vld[g]          <= 1'b0;
      end else if (push_i) begin
        beat_o.data[g*DW_W +: DW_W] <= beat_i.data[g*DW_W +: DW_W];
        beat_o.lane_vld[g]          <= beat_i.lane_vld[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_o.sop <= 1'b0;
      beat_o.eop <= 1'b0;
    end else if (push_i) begin
      beat_o.sop <= beat_i.sop;
      beat_o.eop <= beat_i.eop;
    end
  end
endmodule

// File: rtl/tlp_stream_packer.sv
module tlp_stream_packer
  import tlp_pack_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW_W-1:0]   in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [LANES-1:0]  out_lane_vld
);
  logic           take;
  logic           push;
  logic           space;
  logic [2:0]     hdr_dws;
  logic [LEN_W:0] pay_dws;
  beat_t          beat_nxt;
  beat_t          beat_q;

  assign in_ready = space;
  assign take     = in_valid && space;

  tlp_hdr_decode #(.LEN_W(LEN_W)) u_dec (
    .has_pay_i (in_data[BIT_HAS_PAY]),
    .hdr4_i    (in_data[BIT_HDR4]),
    .len_i     (in_data[LEN_W-1:0]),
    .hdr_dws_o (hdr_dws),
    .pay_dws_o (pay_dws)
  );

  tlp_lane_asm #(.LEN_W(LEN_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take),
    .dw_i      (in_data),
    .hdr_dws_i (hdr_dws),
    .pay_dws_i (pay_dws),
    .push_o    (push),
    .beat_o    (beat_nxt)
  );

  tlp_beat_reg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .beat_i  (beat_nxt),
    .ready_i (out_ready),
    .valid_o (out_valid),
    .space_o (space),
    .beat_o  (beat_q)
  );

  assign out_data     = beat_q.data;
  assign out_sop      = beat_q.sop;
  assign out_eop      = beat_q.eop;
  assign out_lane_vld = beat_q.lane_vld;
endmodule

// File: rtl/tlp_stream_packer_chk.sv
module tlp_stream_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic        out_sop,
  input logic        out_eop,
  input logic [1:0]  out_lane_vld
);
  logic mid_pkt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      mid_pkt <= 1'b0;
    else if (out_valid && out_ready)
      mid_pkt <= !out_eop;
  end

  assert_hold_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_lane_vld) && $stable(out_sop) && $stable(out_eop)));

  assert_stall_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_some_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lane_vld != 2'b00));

  assert_empty_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_lane_vld[1]) |-> (out_data[63:32] == 32'd0));

  assert_empty_lower_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_lane_vld[0]) |-> (out_data[31:0] == 32'd0));

  assert_first_beat_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> (out_lane_vld == 2'b11 && !out_eop));

  assert_sop_framing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sop == !mid_pkt));
endmodule

bind tlp_stream_packer tlp_stream_packer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_sop      (out_sop),
  .out_eop      (out_eop),
  .out_lane_vld (out_lane_vld)
);

// File: tb/tb_tlp_stream_packer.sv
`timescale 1ns/1ps
module tb_tlp_stream_packer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_data;
  logic        out_sop;
  logic        out_eop;
  logic [1:0]  out_lane_vld;

  always #2.5 clk = ~clk;

  tlp_stream_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .out_lane_vld(out_lane_vld)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [31:0] src   [0:1031];
  logic [63:0] exp_d [0:519];
  logic [1:0]  exp_v [0:519];
  logic [63:0] got_d [0:519];
  logic [1:0]  got_v [0:519];
  logic        got_s [0:519];
  logic        got_e [0:519];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode 0: free flow, 1: sink stalls every third cycle, 2: source gaps
  task automatic run_pkt(input bit hdr4, input bit has_pay, input int len_field,
                         input bit addr_odd, input int mode, input string req);
    int nh, npay, ndw, ds, last_slot, nbeats, sent, rcv, cyc, slot, b;
    logic [63:0] held_d;
    bit held;
    nh   = hdr4 ? 4 : 3;
    npay = has_pay ? ((len_field[9:0] == 0) ? 1024 : len_field[9:0]) : 0;
    ndw  = nh + npay;
    for (int i = 0; i < 520; i++) begin exp_d[i] = '0; exp_v[i] = '0; end
    src[0] = {1'b0, has_pay, hdr4, 19'd0, len_field[9:0]};
    src[1] = 32'h1A2B3C4D;
    if (hdr4) begin
      src[2] = 32'h0000_0001;
      src[3] = 32'hFEED_0000 | {29'd0, addr_odd, 2'b00};
    end else begin
      src[2] = 32'hBEEF_1000 | {29'd0, addr_odd, 2'b00};
    end
    for (int i = 0; i < npay; i++) src[nh+i] = 32'hD000_0000 + i;
    // first data slot: next slot at or after the header with parity addr_odd
    ds = nh + (((nh % 2) != int'(addr_odd)) ? 1 : 0);
    for (int i = 0; i < ndw; i++) begin
      slot = (i < nh) ? i : ds + (i - nh);
      b = slot / 2;
      if (slot % 2 == 1) exp_d[b][63:32] = src[i];
      else               exp_d[b][31:0]  = src[i];
      exp_v[b][slot % 2] = 1'b1;
    end
    last_slot = (npay > 0) ? ds + npay - 1 : nh - 1;
    nbeats = last_slot / 2 + 1;
    sent = 0; rcv = 0; cyc = 0; held = 1'b0; held_d = '0;
    while (rcv < nbeats && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (held)
        check(out_valid && out_data == held_d, "R8", out_data, held_d);
      out_ready = (mode == 1) ? (cyc % 3 != 0) : 1'b1;
      in_valid  = (sent < ndw) && !(mode == 2 && cyc % 2 == 0);
      in_data   = (sent < ndw) ? src[sent] : 32'd0;
      #1;
      if (out_valid && !out_ready)
        check(!in_ready, "R9", {63'd0, in_ready}, 64'd0);
      held   = out_valid && !out_ready;
      held_d = out_data;
      if (out_valid && out_ready) begin
        got_d[rcv] = out_data; got_v[rcv] = out_lane_vld;
        got_s[rcv] = out_sop;  got_e[rcv] = out_eop;
        rcv++;
      end
      if (in_valid && in_ready) sent++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(rcv == nbeats, {req, " beat count"}, rcv, nbeats);
    for (int i = 0; i < rcv; i++) begin
      check(got_d[i] == exp_d[i], {req, " data"}, got_d[i], exp_d[i]);
      check(got_v[i] == exp_v[i], "R7 lane valid", {62'd0, got_v[i]}, {62'd0, exp_v[i]});
      check(got_s[i] == (i == 0), "R6 sop", {63'd0, got_s[i]}, {63'd0, i == 0});
      check(got_e[i] == (i == nbeats - 1), "R6 eop", {63'd0, got_e[i]},
            {63'd0, i == nbeats - 1});
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 out_valid", {63'd0, out_valid}, 64'd0);
    check(in_ready == 1'b1, "R11 in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_hdr3_odd;   run_pkt(1'b0, 1'b1, 3, 1'b1, 0, "R1 R3"); endtask
  task automatic t_hdr3_even;  run_pkt(1'b0, 1'b1, 2, 1'b0, 0, "R4");    endtask
  task automatic t_hdr4_even;  run_pkt(1'b1, 1'b1, 1, 1'b0, 0, "R5");    endtask
  task automatic t_hdr4_odd;   run_pkt(1'b1, 1'b1, 2, 1'b1, 0, "R5");    endtask
  task automatic t_read_hdr3;  run_pkt(1'b0, 1'b0, 5, 1'b1, 0, "R10");   endtask
  task automatic t_msg_hdr4;   run_pkt(1'b1, 1'b0, 9, 1'b0, 0, "R10");   endtask
  task automatic t_stall_sink; run_pkt(1'b0, 1'b1, 7, 1'b1, 1, "R8 R9"); endtask
  task automatic t_src_gaps;   run_pkt(1'b1, 1'b1, 5, 1'b1, 2, "R5");    endtask
  task automatic t_max_len;    run_pkt(1'b0, 1'b1, 0, 1'b0, 1, "R2");    endtask
  task automatic t_one_dw_odd; run_pkt(1'b0, 1'b1, 1, 1'b1, 0, "R3");    endtask

  initial begin
    int cycles = 0;
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_hdr3_odd();
    t_hdr3_even();
    t_hdr4_even();
    t_hdr4_odd();
    t_read_hdr3();
    t_msg_hdr4();
    t_stall_sink();
    t_src_gaps();
    t_max_len();
    t_one_dw_odd();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule